// File: doc/BRIEF.md
# Instrument Status Byte and Service-Request Unit

This block gathers the summary levels of an instrument's status groups into one 8-bit status byte, masks that byte with a software-written service-request enable mask, and drives a service-request interrupt line. Three of the summary bits are held here as flags: system error, message available and event-status summary. Pulses set and clear them. The busy, questionable and operation summaries are live levels that come from their owning groups.

The byte can be read in two ways, and each is a combinational view. The query view puts the live masked summary in bit 6 and changes nothing. The serial-poll view puts the latched request flag in bit 6. A one-cycle `poll_i` strobe marks the poll, and the latched flag is cleared at the clock edge that ends that cycle. A clear-status strobe empties the held flags and withdraws any pending request. The request flag latches only when the masked summary rises. A request that has been served therefore does not return until the summary falls and rises again.

Top module: `status_byte_unit`

## Requirements
- R1: The query byte is laid out as follows: bit 0 is busy, bit 1 is always 0, bit 2 is system error, bit 3 is questionable summary, bit 4 is message available, bit 5 is event-status summary, bit 6 is the masked summary (MSS) and bit 7 is operation summary.
- R2: MSS is high exactly when some status bit other than bit 6 is set together with the same bit of the enable mask. Enable bit 6 never contributes. A mask write is visible from the clock edge that captures it.
- R3: The request flag (RQS) sets at the first clock edge at which MSS is high after being low at the previous edge. `srq_o` equals RQS.
- R4: While MSS stays high, RQS does not set again once it has been cleared. It sets again only after MSS has been low at an edge and then rises.
- R5: The poll byte equals the query byte in every bit except bit 6, which carries RQS. A `poll_i` cycle clears RQS at its closing edge and leaves every other bit unchanged.
- R6: If a rising MSS edge falls in the same cycle as a poll, RQS stays set.
- R7: A put pulse sets message available and a read pulse clears it. When both arrive in the same cycle, the bit ends up set.
- R8: An event pulse sets the event-status summary and an event-register read pulse clears it. When both arrive in the same cycle, the bit ends up set.
- R9: An error push sets the system-error bit. The bit then holds until clear-status, whatever the other read pulses do.
- R10: Clear-status empties the system-error, message-available and event-status bits and RQS. It overrides set pulses and MSS edges that arrive in the same cycle.
- R11: After reset the held flags, the enable mask and RQS are all zero, so MSS stays low even when the live inputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Busy level |
| ques_sum_i | input | 1 | Questionable-group summary level |
| oper_sum_i | input | 1 | Operation-group summary level |
| err_push_i | input | 1 | Pulse: an entry was placed in the error queue |
| oq_put_i | input | 1 | Pulse: output queue received data |
| oq_read_i | input | 1 | Pulse: output buffer was read |
| esr_event_i | input | 1 | Pulse: an event-status bit was set |
| esr_read_i | input | 1 | Pulse: event-status register was read |
| clr_stat_i | input | 1 | Pulse: clear-status command |
| sre_we_i | input | 1 | Enable-mask write strobe |
| sre_wdata_i | input | 8 | Enable-mask write data |
| poll_i | input | 1 | Serial-poll strobe, one cycle |
| query_byte_o | output | 8 | Query view, MSS in bit 6 |
| poll_byte_o | output | 8 | Poll view, RQS in bit 6 |
| srq_o | output | 1 | Service-request interrupt |

## Verification
The bench sweeps all 64 combinations of the six real status bits against all 256 mask values. This catches a design that lets enable bit 6 feed the summary, that swaps bit positions, or that lets bit 1 float. Directed sequences then go after the request flag. A level-sensitive latch would re-raise the interrupt right after a poll while the summary stays high. A poll-wins priority would drop a fresh request that rises in the poll cycle. A clear-status that loses to a same-cycle edge or set pulse would leave a stale request or flag behind. The same-cycle put/read and event/read cases expose a design that gives the clear priority over the set.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
// Package sb_pkg
// Shared constants for the status byte unit: byte width and bit positions.
// Assumes an 8-bit status byte whose positions are decoded by bus software.
package sb_pkg;
    localparam int SB_W     = 8;
    localparam int BIT_BUSY = 0;
    localparam int BIT_SYS  = 2;
    localparam int BIT_QUES = 3;
    localparam int BIT_MAV  = 4;
    localparam int BIT_ESB  = 5;
    localparam int BIT_SUM  = 6;
    localparam int BIT_OPER = 7;
    // index of each held flag inside the flag bank
    localparam int FLG_SYS  = 0;
    localparam int FLG_MAV  = 1;
    localparam int FLG_ESB  = 2;
    localparam int N_FLAG   = 3;
endpackage

// File: rtl/sb_flag.sv
`timescale 1ns/1ps
// Module sb_flag
// One held status flag with a set pulse, a read-clear pulse and a global
// clear. The global clear always wins. SET_WINS picks which of set and
// read-clear wins when both arrive in the same cycle.
// Assumes the pulses are synchronous to clk and one cycle wide.
module sb_flag #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_clr_i,
    input  logic clr_all_i,
    output logic q_o
);
    logic q_nxt;

    generate
        if (SET_WINS) begin : g_set_first
            // next value when a new set outranks a read-clear
            always_comb begin
                if (set_i)         q_nxt = 1'b1;
                else if (rd_clr_i) q_nxt = 1'b0;
                else               q_nxt = q_o;
            end
        end else begin : g_clr_first
            // next value when a read-clear outranks a new set
            always_comb begin
                if (rd_clr_i)      q_nxt = 1'b0;
                else if (set_i)    q_nxt = 1'b1;
                else               q_nxt = q_o;
            end
        end
    endgenerate

    // flag register with global clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)         q_o <= 1'b0;
        else if (clr_all_i) q_o <= 1'b0;
        else                q_o <= q_nxt;
    end

    // R10: a global clear always leaves the flag empty
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> !q_o);
    // R7 (also covers R8, R9): an unopposed set leaves the flag high
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_all_i && (SET_WINS || !rd_clr_i)) |=> q_o);
    // R9: with no pulse at all the flag holds
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !rd_clr_i && !clr_all_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/sb_summary.sv
`timescale 1ns/1ps
// Module sb_summary
// Combinational masked summary: high when some status bit is set together
// with its enable bit. Bit SKIP is excluded so that the summary cannot
// feed back into itself.
// Assumes stat_i and en_i share one bit layout.
module sb_summary #(
    parameter int W    = 8,
    parameter int SKIP = 6
) (
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] en_i,
    output logic         mss_o
);
    localparam logic [W-1:0] KEEP = ~(W'(1) << SKIP);

    logic [W-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_hit
            assign hit[i] = stat_i[i] & en_i[i] & KEEP[i];
        end
    endgenerate

    // reduce the per-bit matches to the summary
    always_comb mss_o = |hit;
endmodule

// File: rtl/sb_srq.sv
`timescale 1ns/1ps
// Module sb_srq
// Request flag: latches on a rising edge of the masked summary and clears
// on a serial poll or a clear-status. The order is clear-status first,
// then a new edge, then the poll.
// Assumes poll_i and clr_i are one-cycle strobes.
module sb_srq (
    input  logic clk,
    input  logic rst_n,
    input  logic mss_i,
    input  logic poll_i,
    input  logic clr_i,
    output logic rqs_o
);
    logic mss_q;
    logic rise;

    // summary as seen at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) mss_q <= 1'b0;
        else        mss_q <= mss_i;
    end

    // low-to-high transition of the summary between edges
    always_comb rise = mss_i & ~mss_q;

    // request flag update with fixed priority
    always_ff @(posedge clk) begin
        if (!rst_n)      rqs_o <= 1'b0;
        else if (clr_i)  rqs_o <= 1'b0;
        else if (rise)   rqs_o <= 1'b1;
        else if (poll_i) rqs_o <= 1'b0;
    end

    // R3: a summary that is high after being low raises the request
    assert_rqs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mss_i && !mss_q && !clr_i) |=> rqs_o);
    // R4: a summary that stays high cannot raise it again
    assert_no_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rqs_o && mss_q && mss_i) |=> !rqs_o);
    // R5: a poll with no fresh edge drops the request
    assert_poll_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && !(mss_i && !mss_q)) |=> !rqs_o);
    // R10: clear-status drops the request regardless of edges
    assert_clr_rqs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !rqs_o);
endmodule

// File: rtl/status_byte_unit.sv
`timescale 1ns/1ps
// Module status_byte_unit
// Builds the 8-bit status byte from live summary levels and held flags,
// holds the service-request enable mask, and derives the masked summary,
// the latched request and the two read views.
// Assumes every strobe is one cycle wide and synchronous to clk.
module status_byte_unit
    import sb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy_i,
    input  logic            ques_sum_i,
    input  logic            oper_sum_i,
    input  logic            err_push_i,
    input  logic            oq_put_i,
    input  logic            oq_read_i,
    input  logic            esr_event_i,
    input  logic            esr_read_i,
    input  logic            clr_stat_i,
    input  logic            sre_we_i,
    input  logic [SB_W-1:0] sre_wdata_i,
    input  logic            poll_i,
    output logic [SB_W-1:0] query_byte_o,
    output logic [SB_W-1:0] poll_byte_o,
    output logic            srq_o
);
    logic [SB_W-1:0]   sre_q;
    logic [N_FLAG-1:0] flag_set;
    logic [N_FLAG-1:0] flag_rdclr;
    logic [N_FLAG-1:0] flag_q;
    logic [SB_W-1:0]   stat;
    logic              mss;
    logic              rqs;

    // enable mask register, written by software
    always_ff @(posedge clk) begin
        if (!rst_n)        sre_q <= '0;
        else if (sre_we_i) sre_q <= sre_wdata_i;
    end

    // route the pulses to the flag bank
    always_comb begin
        flag_set             = '0;
        flag_rdclr           = '0;
        flag_set[FLG_SYS]    = err_push_i;
        flag_set[FLG_MAV]    = oq_put_i;
        flag_rdclr[FLG_MAV]  = oq_read_i;
        flag_set[FLG_ESB]    = esr_event_i;
        flag_rdclr[FLG_ESB]  = esr_read_i;
    end

    genvar f;
    generate
        for (f = 0; f < N_FLAG; f++) begin : g_flag
            sb_flag #(.SET_WINS(1'b1)) u_flag (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_i     (flag_set[f]),
                .rd_clr_i  (flag_rdclr[f]),
                .clr_all_i (clr_stat_i),
                .q_o       (flag_q[f])
            );
        end
    endgenerate

    // assemble the status byte without bit 6
    always_comb begin
        stat           = '0;
        stat[BIT_BUSY] = busy_i;
        stat[BIT_SYS]  = flag_q[FLG_SYS];
        stat[BIT_QUES] = ques_sum_i;
        stat[BIT_MAV]  = flag_q[FLG_MAV];
        stat[BIT_ESB]  = flag_q[FLG_ESB];
        stat[BIT_OPER] = oper_sum_i;
    end

    sb_summary #(.W(SB_W), .SKIP(BIT_SUM)) u_sum (
        .stat_i (stat),
        .en_i   (sre_q),
        .mss_o  (mss)
    );

    sb_srq u_srq (
        .clk    (clk),
        .rst_n  (rst_n),
        .mss_i  (mss),
        .poll_i (poll_i),
        .clr_i  (clr_stat_i),
        .rqs_o  (rqs)
    );

    // the two read views differ only in bit 6
    always_comb begin
        query_byte_o          = stat;
        query_byte_o[BIT_SUM] = mss;
        poll_byte_o           = stat;
        poll_byte_o[BIT_SUM]  = rqs;
        srq_o                 = rqs;
    end

    // R5: the two views agree outside bit 6
    assert_views_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((query_byte_o ^ poll_byte_o) & ~(SB_W'(1) << BIT_SUM)) == '0);
    // R2: writing an all-zero mask silences the summary from the next cycle
    assert_zero_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sre_we_i && sre_wdata_i == '0) |=> !query_byte_o[BIT_SUM]);
    // R11: the cycle after reset the mask is empty, so no summary
    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> !query_byte_o[BIT_SUM]);
endmodule

// File: tb/tb_status_byte_unit.sv
`timescale 1ns/1ps
// Bench for status_byte_unit: full sweep of the status pattern against the
// enable mask, then directed sequences for the request flag and the flags.
module tb_status_byte_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_i = 0, ques_sum_i = 0, oper_sum_i = 0;
    logic       err_push_i = 0, oq_put_i = 0, oq_read_i = 0;
    logic       esr_event_i = 0, esr_read_i = 0, clr_stat_i = 0;
    logic       sre_we_i = 0, poll_i = 0;
    logic [7:0] sre_wdata_i = 8'h00;
    logic [7:0] query_byte_o, poll_byte_o;
    logic       srq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    status_byte_unit dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .ques_sum_i(ques_sum_i),
        .oper_sum_i(oper_sum_i), .err_push_i(err_push_i), .oq_put_i(oq_put_i),
        .oq_read_i(oq_read_i), .esr_event_i(esr_event_i), .esr_read_i(esr_read_i),
        .clr_stat_i(clr_stat_i), .sre_we_i(sre_we_i), .sre_wdata_i(sre_wdata_i),
        .poll_i(poll_i), .query_byte_o(query_byte_o), .poll_byte_o(poll_byte_o),
        .srq_o(srq_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // expected query byte from the requirement layout (R1, R2)
    function automatic logic [7:0] exp_query(logic [5:0] p, logic [7:0] m);
        logic [7:0] b;
        b = {p[5], 1'b0, p[4], p[3], p[2], p[1], 1'b0, p[0]};
        b[6] = |(b & m & 8'hBF);
        return b;
    endfunction

    task automatic clear_all();
        clr_stat_i = 1; busy_i = 0; ques_sum_i = 0; oper_sum_i = 0;
        step();
        clr_stat_i = 0;
    endtask

    task automatic write_sre(logic [7:0] v);
        sre_we_i = 1; sre_wdata_i = v;
        step();
        sre_we_i = 0;
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        step(); step(); step();
        rst_n = 1;
        // R11: reset state is all quiet
        chk("R11 query after reset", query_byte_o, 8'h00);
        chk("R11 srq after reset", {7'd0, srq_o}, 8'h00);
        busy_i = 1; oper_sum_i = 1;
        step();
        chk("R11 mask empty after reset", query_byte_o, 8'h81);
        chk("R11 no request after reset", {7'd0, srq_o}, 8'h00);

        // R1 R2 R5 R7 R8 R9: every status pattern against every mask
        for (int p = 0; p < 64; p++) begin
            clear_all();
            err_push_i = p[1]; oq_put_i = p[3]; esr_event_i = p[4];
            busy_i = p[0]; ques_sum_i = p[2]; oper_sum_i = p[5];
            step();
            err_push_i = 0; oq_put_i = 0; esr_event_i = 0;
            for (int m = 0; m < 256; m++) begin
                write_sre(8'(m));
                chk("R1/R2 query sweep", query_byte_o, exp_query(6'(p), 8'(m)));
                chk("R5 poll low bits", poll_byte_o & 8'hBF,
                    exp_query(6'(p), 8'(m)) & 8'hBF);
            end
        end

        // R3: a rising summary raises the request
        clear_all();
        write_sre(8'h01);
        chk("R10 request dropped by clear", {7'd0, srq_o}, 8'h00);
        busy_i = 1;
        step();
        chk("R3 srq raised", {7'd0, srq_o}, 8'h01);
        chk("R3 poll bit6", poll_byte_o, 8'h41);
        // R5: poll returns the flag, then clears only it
        poll_i = 1;
        chk("R5 poll sees request", poll_byte_o, 8'h41);
        step();
        poll_i = 0;
        chk("R5 request cleared by poll", {7'd0, srq_o}, 8'h00);
        chk("R5 other bits kept", query_byte_o, 8'h41);
        // R4: no re-arm while the summary stays high
        step(); step();
        chk("R4 no re-arm while high", {7'd0, srq_o}, 8'h00);
        busy_i = 0;
        step();
        busy_i = 1;
        step();
        chk("R4 re-arm after low", {7'd0, srq_o}, 8'h01);
        // R6: edge in the poll cycle keeps the request
        poll_i = 1;
        step();
        poll_i = 0;
        busy_i = 0;
        step();
        busy_i = 1; poll_i = 1;
        step();
        poll_i = 0;
        chk("R6 edge beats poll", {7'd0, srq_o}, 8'h01);
        // R10: clear-status beats a simultaneous edge
        poll_i = 1;
        step();
        poll_i = 0; busy_i = 0;
        step();
        busy_i = 1; clr_stat_i = 1;
        step();
        clr_stat_i = 0;
        chk("R10 clear beats edge", {7'd0, srq_o}, 8'h00);
        step();
        chk("R10 stays clear while high", {7'd0, srq_o}, 8'h00);

        // R7: message-available set/clear and same-cycle priority
        clear_all();
        write_sre(8'h00);
        oq_put_i = 1;
        step();
        oq_put_i = 0;
        chk("R7 put sets mav", query_byte_o, 8'h10);
        oq_put_i = 1; oq_read_i = 1;
        step();
        oq_put_i = 0; oq_read_i = 0;
        chk("R7 put beats read", query_byte_o, 8'h10);
        oq_read_i = 1;
        step();
        oq_read_i = 0;
        chk("R7 read clears mav", query_byte_o, 8'h00);

        // R8: event-status summary set/clear and same-cycle priority
        esr_event_i = 1;
        step();
        esr_event_i = 0;
        chk("R8 event sets esb", query_byte_o, 8'h20);
        esr_event_i = 1; esr_read_i = 1;
        step();
        esr_event_i = 0; esr_read_i = 0;
        chk("R8 event beats read", query_byte_o, 8'h20);
        esr_read_i = 1;
        step();
        esr_read_i = 0;
        chk("R8 read clears esb", query_byte_o, 8'h00);

        // R9: system error holds through other read pulses
        err_push_i = 1;
        step();
        err_push_i = 0;
        oq_read_i = 1; esr_read_i = 1; poll_i = 1;
        step();
        oq_read_i = 0; esr_read_i = 0; poll_i = 0;
        step();
        chk("R9 sys error holds", query_byte_o, 8'h04);

        // R10: clear-status beats same-cycle set pulses
        clr_stat_i = 1; err_push_i = 1; oq_put_i = 1; esr_event_i = 1;
        step();
        clr_stat_i = 0; err_push_i = 0; oq_put_i = 0; esr_event_i = 0;
        chk("R10 clear beats sets", query_byte_o, 8'h00);

        finish_up();
    end
endmodule